// File: doc/BRIEF.md
# Three-Wire Audio Link Frame Master

This block drives the bit level of a three-wire audio codec link as frame master. A codec supplies the bit clock `bclk`. The block produces the frame sync and shifts a 256-bit frame out on `ser_out`. The frame is one 16-bit tag word followed by twelve 20-bit slot words. In lockstep it shifts the codec's frame in from `ser_in` using the same frame timing. No slot is ever skipped: every word goes out and comes in on every frame.

The layer above presents the outgoing tag and slots as parallel words and reads the incoming frame back as parallel words. A one-cycle `frame_tick` marks the frame boundary. At that point the incoming frame has just been completed and the outgoing words have just been sampled for the frame now starting. The layer above therefore has a whole frame period to consume the received words and prepare the next outgoing ones. While `link_en` is low the link is quiet.

Top module: `ac_link_framer`

## Requirements
- R1: A frame lasts exactly 256 bit clocks. While enabled, `frame_tick` is high for one bit clock per frame, and consecutive ticks are 256 bit clocks apart.
- R2: `ser_out` changes only on the rising edge of `bclk`, one bit per clock, MSB first. The order is tag bit 15 down to bit 0, then `tx_slot[0]` (slot 1) bit 19 down to bit 0, and so on through `tx_slot[11]` (slot 12).
- R3: `frame_sync` is active high for exactly 16 consecutive bit clocks. It rises for the final bit of the previous frame (one bit before tag bit 15) and falls after the fifteenth tag bit.
- R4: `ser_in` is sampled on the falling edge of `bclk` in the same bit layout as R2. The completed frame appears on `rx_tag` and on `rx_slot[k]` (slot k+1).
- R5: `tx_tag` and `tx_slot` are sampled at the rising edge that starts tag bit 15, which is the edge that raises `frame_tick`. Changes at any other time do not alter the frame being sent.
- R6: When `link_en` is low at a rising edge, `frame_sync`, `ser_out` and `frame_tick` are low from that edge on, and `ser_in` is not captured.
- R7: After `link_en` goes high, the first bit period is a lead-in with `frame_sync` high and `ser_out` low, followed by tag bit 15. No `frame_tick` is given at the start of this first frame.
- R8: Synchronous active-high reset (sampled on the rising edge of `bclk`) drives `frame_sync`, `ser_out` and `frame_tick` low and clears `rx_tag` and `rx_slot` to zero.
- R9: `rx_tag` and `rx_slot` keep the last complete frame until the next frame completes. A partial frame cut short by disabling leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock from the codec |
| rst | input | 1 | Synchronous active-high reset |
| link_en | input | 1 | Enables transmit and receive together |
| tx_tag | input | 16 | Outgoing tag word |
| tx_slot | input | 12x20 | Outgoing slot words; element k is slot k+1 |
| ser_in | input | 1 | Serial data from the codec |
| frame_sync | output | 1 | Frame sync, active high |
| ser_out | output | 1 | Serial data to the codec |
| frame_tick | output | 1 | One-cycle frame boundary strobe |
| rx_tag | output | 16 | Last received tag word |
| rx_slot | output | 12x20 | Last received slot words; element k is slot k+1 |

## Verification
The checker watches the link shape on every bit clock:
- each sync pulse lasts 16 clocks unless disabling cuts it short;
- boundary ticks are 256 clocks apart;
- a tick always falls inside a sync pulse that began one bit earlier;
- the lead-in bit follows each enable;
- the link goes quiet after a disable.

Only the bench scenarios can show the data content. These cover the bit order of the tag and of every slot, the falling-edge capture of a known incoming frame, the rule that tx words changed mid-frame do not alter the current frame, and the received words being held through a disable.

// File: rtl/ac_link_pkg.sv
package ac_link_pkg;
    localparam int TAG_BITS   = 16;
    localparam int SLOT_BITS  = 20;
    localparam int NUM_SLOTS  = 12;
    localparam int FRAME_BITS = TAG_BITS + NUM_SLOTS * SLOT_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS);

    typedef logic [NUM_SLOTS-1:0][SLOT_BITS-1:0] slot_vec_t;
    typedef logic [FRAME_BITS-1:0]               frame_bits_t;

    typedef struct packed {
        logic [TAG_BITS-1:0] tag;
        slot_vec_t           slot;
    } frame_words_t;

    // Serial order: tag first, then slot element 0 (slot 1) up to the last.
    function automatic frame_bits_t frame_pack(input frame_words_t w);
        frame_bits_t f;
        f = '0;
        f[FRAME_BITS-1 -: TAG_BITS] = w.tag;
        for (int k = 0; k < NUM_SLOTS; k++)
            f[FRAME_BITS-TAG_BITS-1-k*SLOT_BITS -: SLOT_BITS] = w.slot[k];
        return f;
    endfunction

    function automatic frame_words_t frame_unpack(input frame_bits_t f);
        frame_words_t w;
        w.tag = f[FRAME_BITS-1 -: TAG_BITS];
        for (int k = 0; k < NUM_SLOTS; k++)
            w.slot[k] = f[FRAME_BITS-TAG_BITS-1-k*SLOT_BITS -: SLOT_BITS];
        return w;
    endfunction
endpackage

// File: rtl/ac_link_timing.sv
module ac_link_timing
    import ac_link_pkg::*;
(
    input  logic             bclk,
    input  logic             rst,
    input  logic             link_en,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] nxt_pos,
    output logic             run,
    output logic             in_frame,
    output logic             frame_sync,
    output logic             frame_tick
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
    localparam logic [POS_W-1:0] SYNC_END = POS_W'(TAG_BITS - 1);

    always_comb begin
        if (!run)
            nxt_pos = LAST_POS;
        else if (pos == LAST_POS)
            nxt_pos = '0;
        else
            nxt_pos = pos + 1'b1;
    end

    always_ff @(posedge bclk) begin
        if (rst || !link_en) begin
            pos        <= LAST_POS;
            run        <= 1'b0;
            in_frame   <= 1'b0;
            frame_sync <= 1'b0;
            frame_tick <= 1'b0;
        end else begin
            pos        <= nxt_pos;
            run        <= 1'b1;
            frame_sync <= (nxt_pos == LAST_POS) || (nxt_pos < SYNC_END);
            frame_tick <= (nxt_pos == '0) && in_frame;
            if (nxt_pos == '0)
                in_frame <= 1'b1;
        end
    end
endmodule

// File: rtl/ac_link_tx_shift.sv
module ac_link_tx_shift
    import ac_link_pkg::*;
(
    input  logic             bclk,
    input  logic             rst,
    input  logic             link_en,
    input  logic             run,
    input  logic [POS_W-1:0] nxt_pos,
    input  frame_bits_t      tx_frame,
    output logic             ser_out
);
    frame_bits_t shreg;

    always_ff @(posedge bclk) begin
        if (rst || !link_en) begin
            shreg   <= '0;
            ser_out <= 1'b0;
        end else if (!run) begin
            ser_out <= 1'b0;
        end else if (nxt_pos == '0) begin
            ser_out <= tx_frame[FRAME_BITS-1];
            shreg   <= tx_frame << 1;
        end else begin
            ser_out <= shreg[FRAME_BITS-1];
            shreg   <= shreg << 1;
        end
    end
endmodule

// File: rtl/ac_link_rx_shift.sv
module ac_link_rx_shift
    import ac_link_pkg::*;
(
    input  logic             bclk,
    input  logic             rst,
    input  logic             run,
    input  logic             in_frame,
    input  logic [POS_W-1:0] pos,
    input  logic             ser_in,
    output frame_bits_t      rx_frame
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    frame_bits_t shreg;
    frame_bits_t shifted;

    assign shifted = {shreg[FRAME_BITS-2:0], ser_in};

    always_ff @(negedge bclk) begin
        if (rst) begin
            shreg    <= '0;
            rx_frame <= '0;
        end else if (run) begin
            shreg <= shifted;
            if (in_frame && pos == LAST_POS)
                rx_frame <= shifted;
        end
    end
endmodule

// File: rtl/ac_link_framer.sv
module ac_link_framer
    import ac_link_pkg::*;
(
    input  logic                bclk,
    input  logic                rst,
    input  logic                link_en,
    input  logic [TAG_BITS-1:0] tx_tag,
    input  slot_vec_t           tx_slot,
    input  logic                ser_in,
    output logic                frame_sync,
    output logic                ser_out,
    output logic                frame_tick,
    output logic [TAG_BITS-1:0] rx_tag,
    output slot_vec_t           rx_slot
);
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] nxt_pos;
    logic             run;
    logic             in_frame;
    frame_bits_t      tx_frame;
    frame_bits_t      rx_frame;
    frame_words_t     tx_words;
    frame_words_t     rx_words;

    assign tx_words.tag  = tx_tag;
    assign tx_words.slot = tx_slot;
    assign tx_frame      = frame_pack(tx_words);
    assign rx_words      = frame_unpack(rx_frame);
    assign rx_tag        = rx_words.tag;
    assign rx_slot       = rx_words.slot;

    ac_link_timing u_timing (
        .bclk       (bclk),
        .rst        (rst),
        .link_en    (link_en),
        .pos        (pos),
        .nxt_pos    (nxt_pos),
        .run        (run),
        .in_frame   (in_frame),
        .frame_sync (frame_sync),
        .frame_tick (frame_tick)
    );

    ac_link_tx_shift u_tx (
        .bclk     (bclk),
        .rst      (rst),
        .link_en  (link_en),
        .run      (run),
        .nxt_pos  (nxt_pos),
        .tx_frame (tx_frame),
        .ser_out  (ser_out)
    );

    ac_link_rx_shift u_rx (
        .bclk     (bclk),
        .rst      (rst),
        .run      (run),
        .in_frame (in_frame),
        .pos      (pos),
        .ser_in   (ser_in),
        .rx_frame (rx_frame)
    );
endmodule

// File: rtl/ac_link_framer_chk.sv
module ac_link_framer_chk
    import ac_link_pkg::*;
(
    input logic bclk,
    input logic rst,
    input logic link_en,
    input logic frame_sync,
    input logic ser_out,
    input logic frame_tick
);
    logic [POS_W:0] hi_len;
    logic [POS_W:0] gap;
    logic           seen_tick;

    always_ff @(posedge bclk) begin
        if (rst) begin
            hi_len    <= '0;
            gap       <= '0;
            seen_tick <= 1'b0;
        end else begin
            hi_len    <= frame_sync ? hi_len + 1'b1 : '0;
            gap       <= frame_tick ? '0 : gap + 1'b1;
            seen_tick <= !link_en ? 1'b0 : (frame_tick ? 1'b1 : seen_tick);
        end
    end

    // R6
    off_quiet_chk: assert property (@(posedge bclk) disable iff (rst)
        !link_en |=> (!frame_sync && !ser_out && !frame_tick));

    // R3
    sync_width_chk: assert property (@(posedge bclk) disable iff (rst)
        ($fell(frame_sync) && $past(link_en)) |-> (hi_len == (POS_W+1)'(TAG_BITS)));

    // R1
    tick_period_chk: assert property (@(posedge bclk) disable iff (rst)
        (frame_tick && seen_tick) |-> (gap == (POS_W+1)'(FRAME_BITS - 1)));

    // R3
    tick_in_sync_chk: assert property (@(posedge bclk) disable iff (rst)
        frame_tick |-> (frame_sync && $past(frame_sync)));

    // R7
    lead_in_chk: assert property (@(posedge bclk) disable iff (rst)
        (link_en && !$past(link_en)) |=> (frame_sync && !ser_out && !frame_tick));
endmodule

bind ac_link_framer ac_link_framer_chk u_chk (
    .bclk       (bclk),
    .rst        (rst),
    .link_en    (link_en),
    .frame_sync (frame_sync),
    .ser_out    (ser_out),
    .frame_tick (frame_tick)
);

// File: tb/ac_link_framer_tb.sv
module ac_link_framer_tb;
    import ac_link_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 4;
    // {tx tag, tx slot seed, rx slot seed, rx tag}
    localparam logic [71:0] VEC [NV] = '{
        {16'h9FF8, 20'hA5A5A, 20'h13579, 16'hF800},
        {16'hFFFF, 20'hFFFFF, 20'h00000, 16'h0000},
        {16'h0000, 20'h00000, 20'hFFFFF, 16'hFFFF},
        {16'h8001, 20'h80001, 20'h7FFFE, 16'h6C3A}
    };

    logic bclk = 1'b0;
    logic rst = 1'b1;
    logic link_en = 1'b0;
    logic ser_in = 1'b0;
    logic [TAG_BITS-1:0] tx_tag;
    slot_vec_t tx_slot;
    logic frame_sync, ser_out, frame_tick;
    logic [TAG_BITS-1:0] rx_tag;
    slot_vec_t rx_slot;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) bclk = ~bclk;

    ac_link_framer u_dut (
        .bclk(bclk), .rst(rst), .link_en(link_en), .tx_tag(tx_tag),
        .tx_slot(tx_slot), .ser_in(ser_in), .frame_sync(frame_sync),
        .ser_out(ser_out), .frame_tick(frame_tick), .rx_tag(rx_tag),
        .rx_slot(rx_slot)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] slot_word(input logic [19:0] seed, input int k);
        logic [39:0] d;
        d = {seed, seed} << k;
        return d[39:20];
    endfunction

    // Serial order: tag, then slot 1 .. slot 12
    function automatic logic [255:0] serial_frame(input logic [15:0] tag, input logic [19:0] seed);
        logic [255:0] f;
        f = 256'(tag);
        for (int k = 0; k < 12; k++) f = (f << 20) | 256'(slot_word(seed, k));
        return f;
    endfunction

    // Port layout: rx_tag above rx_slot[11] .. rx_slot[0]
    function automatic logic [255:0] port_frame(input logic [15:0] tag, input logic [19:0] seed);
        logic [255:0] f;
        f = 256'(tag);
        for (int k = 11; k >= 0; k--) f = (f << 20) | 256'(slot_word(seed, k));
        return f;
    endfunction

    task automatic apply_tx(input int v);
        tx_tag = VEC[v][71:56];
        for (int k = 0; k < 12; k++) tx_slot[k] = slot_word(VEC[v][55:36], k);
    endtask

    task automatic step();
        @(posedge bclk);
        #2;
    endtask

    // Entered at bit 0 (tag MSB) of a frame carrying vector v.
    task automatic run_frame(input int v, input int next_v, input bit tick_first);
        logic [255:0] txf;
        logic [255:0] rxf;
        int e_sdo, e_sync, e_tick;
        txf = serial_frame(VEC[v][71:56], VEC[v][55:36]);
        rxf = serial_frame(VEC[v][15:0], VEC[v][35:16]);
        e_sdo = 0; e_sync = 0; e_tick = 0;
        for (int i = 0; i < 256; i++) begin
            if (ser_out !== txf[255-i]) e_sdo++;
            if (frame_sync !== ((i < 15) || (i == 255))) e_sync++;
            if (frame_tick !== ((i == 0) && tick_first)) e_tick++;
            ser_in = rxf[255-i];
            if (i == 100 && next_v >= 0) apply_tx(next_v);
            step();
        end
        chk(e_sdo == 0, "R2 R5", "serial bit mismatches", 256'(e_sdo), 256'd0);
        chk(e_sync == 0, "R3", "sync mismatches", 256'(e_sync), 256'd0);
        chk(e_tick == 0, "R1", "tick mismatches", 256'(e_tick), 256'd0);
        chk(frame_tick === 1'b1, "R5", "boundary tick", 256'(frame_tick), 256'd1);
        chk({rx_tag, rx_slot} === port_frame(VEC[v][15:0], VEC[v][35:16]), "R4",
            "received words", {rx_tag, rx_slot}, port_frame(VEC[v][15:0], VEC[v][35:16]));
    endtask

    initial begin
        repeat (100000) @(posedge bclk);
        failures++;
        checks++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int e_off;
        apply_tx(0);
        repeat (5) step();
        rst = 1'b0;
        step();
        step();
        // R8 reset state
        chk(frame_sync === 1'b0, "R8", "sync after reset", 256'(frame_sync), 256'd0);
        chk(ser_out === 1'b0, "R8", "data after reset", 256'(ser_out), 256'd0);
        chk(frame_tick === 1'b0, "R8", "tick after reset", 256'(frame_tick), 256'd0);
        chk({rx_tag, rx_slot} === 256'd0, "R8", "rx after reset", {rx_tag, rx_slot}, 256'd0);

        link_en = 1'b1;
        step();
        // R7 lead-in bit
        chk(frame_sync === 1'b1 && ser_out === 1'b0, "R7", "lead-in",
            256'({frame_sync, ser_out}), 256'b10);
        step();
        for (int v = 0; v < NV; v++)
            run_frame(v, (v < NV - 1) ? v + 1 : -1, v > 0);

        // R6 disable mid-frame, R9 rx holds
        repeat (50) step();
        link_en = 1'b0;
        step();
        e_off = 0;
        for (int i = 0; i < 300; i++) begin
            if (frame_sync !== 1'b0 || ser_out !== 1'b0 || frame_tick !== 1'b0) e_off++;
            ser_in = i[0];
            step();
        end
        chk(e_off == 0, "R6", "activity while disabled", 256'(e_off), 256'd0);
        chk({rx_tag, rx_slot} === port_frame(VEC[3][15:0], VEC[3][35:16]), "R9",
            "rx held over disable", {rx_tag, rx_slot}, port_frame(VEC[3][15:0], VEC[3][35:16]));

        // R7 re-enable: lead-in, no tick on first frame start
        apply_tx(1);
        link_en = 1'b1;
        step();
        chk(frame_sync === 1'b1 && ser_out === 1'b0, "R7", "lead-in again",
            256'({frame_sync, ser_out}), 256'b10);
        step();
        run_frame(1, -1, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule